// File: doc/BRIEF.md
# Asynchronous Host Bus to Dual-Port RAM Bridge

This block connects the external memory bus of a microcontroller to one port of an on-chip dual-port RAM. The other RAM port serves a local requester inside the chip. The host bus has no wait or ready line, so an access can never be stretched. Ownership of the RAM is therefore settled in advance through a hardware semaphore that both sides must hold before they touch the array.

Every host control, address and data line passes through a two-flop synchronizer into the system clock. Chip select and output enable can go active up to one bus clock before the address settles. For that reason the address is only latched once the synchronized chip select has been seen active on two consecutive system clocks. The latched address is decoded against a window that holds the RAM words plus one semaphore word just past the last RAM word. Any access outside the window, or one that is misaligned, is treated as a miss.

Reads are served from a registered RAM or semaphore value and driven out through a data output with an enable. Writes are committed on the trailing (deasserting) edge of the write strobe.

Top module: `hbus_dpram_bridge`

## Requirements
- R1: After reset the data-output enable and the local grant are low, and the semaphore is free, so the first host read of the semaphore word returns 1.
- R2: An access begins only after the synchronized chip select has been active for two consecutive clocks. A read whose address changes during the first bus clock of chip select returns the data at the final address.
- R3: A host holding the semaphore that writes a RAM word within the window stores the data present at the trailing edge of the write strobe. A later read of that word returns it.
- R4: A host write to a RAM word while the host does not hold the semaphore leaves the RAM unchanged.
- R5: A host read of the semaphore word (window base + DEPTH*bytes) returns 1 in bit 0 and gives the host the grant when the semaphore is free or already held by the host. It returns 0 and changes nothing while the local side holds it.
- R6: A host write of 0 to the semaphore word releases a host-held grant. A non-zero write leaves it held.
- R7: When a host semaphore read and a local request meet a free semaphore in the same clock, the host wins and the local grant stays low.
- R8: The local side receives its grant only while it requests and the semaphore is not held by the host. It loses the grant the clock after dropping its request. Local RAM reads and writes take effect only while granted.
- R9: Host accesses that fall outside the window, or whose address has a nonzero low bit below the access size, modify no RAM word and do not enable the data output.
- R10: The data-output enable is high only while the synchronized chip select and output enable are active and the write strobe is inactive, for an in-window access. It is low at all other times.
- R11: A host read of a RAM word without holding the semaphore returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_we_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | ADDR_W | Host byte address |
| host_din | input | DATA_W | Host write data |
| host_dout | output | DATA_W | Read data toward the host |
| host_dout_oe | output | 1 | Drive enable for the host data pins (low = high impedance) |
| loc_req | input | 1 | Local semaphore request, held while access is wanted |
| loc_gnt | output | 1 | Local semaphore grant |
| loc_en | input | 1 | Local RAM access strobe |
| loc_we | input | 1 | Local write select (1 = write) |
| loc_idx | input | IDX_W | Local RAM word index |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Local read data, valid the clock after a read strobe |

## Verification
The hardest case to reach is the semaphore tie. A host semaphore read and a local request must hit a free semaphore on exactly the same clock edge, yet the host read only takes effect after the synchronizer and the two-clock chip-select qualification. The bench counts that latency from the negative edge on which it asserts chip select. It raises the local request on the fourth following negative edge, so both arrive at the edge where the read launches. It then checks that the host read returns 1 and that the local grant stays low until the host writes 0.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  typedef enum logic [1:0] {K_NONE, K_RAM, K_SEM} acc_kind_e;
  typedef enum logic [1:0] {O_FREE, O_HOST, O_LOCAL} owner_e;

  // Classify a byte address against the window: RAM words, then one semaphore word.
  function automatic acc_kind_e decode(input logic [31:0] a, input logic [31:0] base,
                                       input int unsigned depth, input int unsigned align);
    logic [31:0] off;
    logic [31:0] span;
    logic [31:0] mask;
    off  = a - base;
    span = 32'(depth) << align;
    mask = (32'd1 << align) - 32'd1;
    if (((a & mask) != 32'd0) || (a < base)) return K_NONE;
    if (off < span) return K_RAM;
    if (off == span) return K_SEM;
    return K_NONE;
  endfunction

  function automatic logic [31:0] word_idx(input logic [31:0] a, input logic [31:0] base,
                                           input int unsigned align);
    return (a - base) >> align;
  endfunction

endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbb_sema.sv
module hbb_sema (
  input  logic clk,
  input  logic rst_n,
  input  logic host_take,
  input  logic host_release,
  input  logic loc_req,
  output logic host_owns,
  output logic loc_gnt,
  output logic sem_free,
  output logic sem_can_take
);
  import hbb_pkg::*;

  owner_e owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= O_FREE;
    end else begin
      case (owner)
        O_FREE: begin
          if (host_take)    owner <= O_HOST;
          else if (loc_req) owner <= O_LOCAL;
        end
        O_HOST:  if (host_release) owner <= O_FREE;
        O_LOCAL: if (!loc_req)     owner <= O_FREE;
        default: owner <= O_FREE;
      endcase
    end
  end

  assign host_owns    = (owner == O_HOST);
  assign loc_gnt      = (owner == O_LOCAL);
  assign sem_free     = (owner == O_FREE);
  assign sem_can_take = (owner != O_LOCAL);
endmodule

// File: rtl/hbb_ram.sv
module hbb_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_idx] <= a_wdata;
      else      a_rdata    <= mem[a_idx];
    end
    if (b_en) begin
      if (b_we) mem[b_idx] <= b_wdata;
      else      b_rdata    <= mem[b_idx];
    end
  end
endmodule

// File: rtl/hbb_host_ctl.sv
module hbb_host_ctl #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter int          DEPTH    = 64,
  parameter logic [31:0] WIN_BASE = 32'h4000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ALIGN = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic              host_owns,
  input  logic              sem_can_take,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              acc_act,
  output logic              win_ram,
  output logic              host_take,
  output logic              host_release,
  output logic              ram_en,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  import hbb_pkg::*;

  logic              cs_d, we_d, rd_done;
  logic              rd_ram_q, rd_ok_q, sem_bit_q;
  logic [ADDR_W-1:0] addr_q;
  acc_kind_e         kind;
  logic              cs_ok, in_win, rd_launch, wr_strobe;

  assign cs_ok     = cs_s & cs_d;
  assign kind      = decode(32'(addr_q), WIN_BASE, DEPTH, ALIGN);
  assign in_win    = acc_act & (kind != K_NONE);
  assign win_ram   = acc_act & (kind == K_RAM);
  assign rd_launch = in_win & oe_s & ~we_s & ~rd_done;
  assign wr_strobe = acc_act & we_d & ~we_s;

  assign host_take    = rd_launch & (kind == K_SEM);
  assign host_release = wr_strobe & (kind == K_SEM) & (wdata_s == '0);
  assign ram_we       = wr_strobe & win_ram & host_owns;
  assign ram_en       = ram_we | (rd_launch & win_ram & host_owns);
  assign ram_idx      = IDX_W'(word_idx(32'(addr_q), WIN_BASE, ALIGN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d      <= 1'b0;
      we_d      <= 1'b0;
      acc_act   <= 1'b0;
      addr_q    <= '0;
      rd_done   <= 1'b0;
      rd_ram_q  <= 1'b0;
      rd_ok_q   <= 1'b0;
      sem_bit_q <= 1'b0;
    end else begin
      cs_d <= cs_s;
      we_d <= we_s;
      if (!cs_s) begin
        acc_act <= 1'b0;
      end else if (cs_ok && !acc_act) begin
        acc_act <= 1'b1;
        addr_q  <= addr_s;
      end
      if (!cs_s || !acc_act) rd_done <= 1'b0;
      else if (rd_launch)    rd_done <= 1'b1;
      if (rd_launch) begin
        rd_ram_q  <= (kind == K_RAM);
        rd_ok_q   <= host_owns;
        sem_bit_q <= sem_can_take;
      end
    end
  end

  assign dout_oe = in_win & cs_s & oe_s & ~we_s & rd_done;
  assign dout    = rd_ram_q ? (rd_ok_q ? ram_rdata : '0)
                            : {{(DATA_W-1){1'b0}}, sem_bit_q};
endmodule

// File: rtl/hbus_dpram_bridge.sv
module hbus_dpram_bridge #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter int          DEPTH    = 64,
  parameter logic [31:0] WIN_BASE = 32'h4000,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_oe,
  input  logic              loc_req,
  output logic              loc_gnt,
  input  logic              loc_en,
  input  logic              loc_we,
  input  logic [IDX_W-1:0]  loc_idx,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);
  localparam int SYNC_W = 3 + ADDR_W + DATA_W;

  logic [SYNC_W-1:0] sync_in, sync_out;
  logic              cs_s, oe_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;

  assign sync_in = {~host_cs_n, ~host_oe_n, ~host_we_n, host_addr, host_din};
  assign {cs_s, oe_s, we_s, addr_s, wdata_s} = sync_out;

  hbb_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );

  logic              host_owns, sem_free, sem_can_take, host_take, host_release;
  logic              acc_act, win_ram, ram_a_en, ram_a_we, ram_b_en;
  logic [IDX_W-1:0]  ram_a_idx;
  logic [DATA_W-1:0] ram_a_rdata;

  hbb_sema u_sema (
    .clk(clk), .rst_n(rst_n), .host_take(host_take), .host_release(host_release),
    .loc_req(loc_req), .host_owns(host_owns), .loc_gnt(loc_gnt),
    .sem_free(sem_free), .sem_can_take(sem_can_take)
  );

  hbb_host_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WIN_BASE(WIN_BASE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .wdata_s(wdata_s), .host_owns(host_owns),
    .sem_can_take(sem_can_take), .ram_rdata(ram_a_rdata),
    .acc_act(acc_act), .win_ram(win_ram), .host_take(host_take),
    .host_release(host_release), .ram_en(ram_a_en), .ram_we(ram_a_we),
    .ram_idx(ram_a_idx), .dout(host_dout), .dout_oe(host_dout_oe)
  );

  assign ram_b_en = loc_en & loc_gnt;

  hbb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .a_en(ram_a_en), .a_we(ram_a_we), .a_idx(ram_a_idx), .a_wdata(wdata_s),
    .a_rdata(ram_a_rdata),
    .b_en(ram_b_en), .b_we(loc_we), .b_idx(loc_idx), .b_wdata(loc_wdata),
    .b_rdata(loc_rdata)
  );
endmodule

// File: rtl/hbb_chk.sv
module hbb_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic oe_s,
  input logic we_s,
  input logic acc_act,
  input logic win_ram,
  input logic host_owns,
  input logic loc_gnt,
  input logic loc_req,
  input logic sem_free,
  input logic host_take,
  input logic ram_a_en,
  input logic ram_a_we,
  input logic ram_b_en,
  input logic dout_oe
);
  // R10
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (cs_s && oe_s && !we_s));
  // R2
  addr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_act) |-> $past(cs_s));
  // R4
  host_wr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_a_we |-> host_owns);
  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_a_en && ram_b_en));
  // R7
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_free && host_take && loc_req) |=> (host_owns && !loc_gnt));
  // R8
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_gnt) |-> $past(loc_req));
  // R9
  ram_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_a_en |-> win_ram);
endmodule

bind hbus_dpram_bridge hbb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
  .acc_act(acc_act), .win_ram(win_ram), .host_owns(host_owns),
  .loc_gnt(loc_gnt), .loc_req(loc_req), .sem_free(sem_free),
  .host_take(host_take), .ram_a_en(ram_a_en), .ram_a_we(ram_a_we),
  .ram_b_en(ram_b_en), .dout_oe(host_dout_oe)
);

// File: tb/sim_hbus_dpram_bridge.sv
`timescale 1ns/1ps
module sim_hbus_dpram_bridge;
  localparam int AW = 16, DW = 16, DEPTH = 64, IW = 6;
  localparam logic [15:0] BASE = 16'h4000;
  localparam logic [15:0] SEM  = 16'h4080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_cs_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_din = '0, host_dout, loc_rdata, loc_wdata = '0;
  logic host_dout_oe, loc_gnt;
  logic loc_req = 1'b0, loc_en = 1'b0, loc_we = 1'b0;
  logic [IW-1:0] loc_idx = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string   q_tag[$];
  logic [DW-1:0] q_val[$];
  event samp_ev;

  always #2.5 clk = ~clk;

  hbus_dpram_bridge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .WIN_BASE(32'h4000)) u0 (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_oe_n(host_oe_n),
    .host_we_n(host_we_n), .host_addr(host_addr), .host_din(host_din),
    .host_dout(host_dout), .host_dout_oe(host_dout_oe), .loc_req(loc_req),
    .loc_gnt(loc_gnt), .loc_en(loc_en), .loc_we(loc_we), .loc_idx(loc_idx),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected item when the driver signals that read data is valid.
  initial forever begin
    @(samp_ev);
    if (q_val.size() == 0) chk(1'b0, "queue", '0, '0);
    else begin
      automatic string t = q_tag.pop_front();
      automatic logic [DW-1:0] v = q_val.pop_front();
      chk(host_dout_oe === 1'b1, {t, " oe"}, {15'd0, host_dout_oe}, 16'd1);
      chk(host_dout === v, t, host_dout, v);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_addr = a; host_din = d; host_cs_n = 1'b0;
    idle(6); host_we_n = 1'b0;
    idle(6);
    chk(host_dout_oe === 1'b0, "R10 no drive in write", {15'd0, host_dout_oe}, 16'd0);
    host_we_n = 1'b1;
    idle(6); host_cs_n = 1'b1;
    idle(6);
  endtask

  task automatic host_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag,
                           input bit early);
    q_tag.push_back(tag); q_val.push_back(exp);
    host_addr = early ? 16'h5000 : a;
    host_cs_n = 1'b0; host_oe_n = 1'b0;
    idle(1); host_addr = a;
    idle(9); -> samp_ev;
    idle(1); host_oe_n = 1'b1; host_cs_n = 1'b1;
    idle(6);
    chk(host_dout_oe === 1'b0, "R10 released", {15'd0, host_dout_oe}, 16'd0);
  endtask

  task automatic host_read_nodrive(input logic [AW-1:0] a, input string tag);
    host_addr = a; host_cs_n = 1'b0; host_oe_n = 1'b0;
    idle(10);
    chk(host_dout_oe === 1'b0, tag, {15'd0, host_dout_oe}, 16'd0);
    host_oe_n = 1'b1; host_cs_n = 1'b1;
    idle(6);
  endtask

  task automatic loc_access(input bit we, input logic [IW-1:0] i, input logic [DW-1:0] d);
    loc_we = we; loc_idx = i; loc_wdata = d; loc_en = 1'b1;
    idle(1); loc_en = 1'b0; loc_we = 1'b0;
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    chk(host_dout_oe === 1'b0, "R1 oe", {15'd0, host_dout_oe}, 16'd0);
    chk(loc_gnt === 1'b0, "R1 gnt", {15'd0, loc_gnt}, 16'd0);
    host_read(SEM, 16'd1, "R1 R5 sem free", 1'b0);
    // R3 writes with grant, including last word
    host_write(BASE, 16'hA5A5);
    host_write(BASE + 16'd2, 16'h1234);
    host_write(BASE + 16'd126, 16'hBEEF);
    host_read(BASE, 16'hA5A5, "R3 word0", 1'b0);
    host_read(BASE + 16'd126, 16'hBEEF, "R3 last", 1'b0);
    // R9 misaligned and out-of-window
    host_write(BASE + 16'd1, 16'hFFFF);
    host_write(16'h5000, 16'hFFFF);
    host_read(BASE, 16'hA5A5, "R9 word0 intact", 1'b0);
    host_read(BASE + 16'd2, 16'h1234, "R9 word1 intact", 1'b0);
    host_read_nodrive(16'h5000, "R9 R10 outside no drive");
    host_read_nodrive(BASE + 16'd3, "R9 misaligned no drive");
    // R2 early chip select
    host_read(BASE + 16'd2, 16'h1234, "R2 early cs", 1'b1);
    // R6 nonzero write keeps, zero write releases
    host_write(SEM, 16'h0001);
    loc_req = 1'b1; idle(3);
    chk(loc_gnt === 1'b0, "R6 still held", {15'd0, loc_gnt}, 16'd0);
    host_write(SEM, 16'h0000);
    idle(1);
    chk(loc_gnt === 1'b1, "R6 R8 released to local", {15'd0, loc_gnt}, 16'd1);
    host_read(SEM, 16'd0, "R5 sem busy", 1'b0);
    host_write(BASE, 16'h0000);
    host_read(BASE, 16'd0, "R11 read no grant", 1'b0);
    loc_access(1'b0, 6'd0, '0);
    chk(loc_rdata === 16'hA5A5, "R4 R8 write without grant ignored", loc_rdata, 16'hA5A5);
    loc_access(1'b1, 6'd1, 16'h7777);
    loc_req = 1'b0; idle(1);
    chk(loc_gnt === 1'b0, "R8 drop", {15'd0, loc_gnt}, 16'd0);
    loc_access(1'b1, 6'd1, 16'h9999);
    host_read(SEM, 16'd1, "R5 sem retake", 1'b0);
    host_read(BASE + 16'd2, 16'h7777, "R8 local write seen", 1'b0);
    // R7 tie: local request lands on the host launch edge
    host_write(SEM, 16'h0000);
    q_tag.push_back("R7 tie host wins"); q_val.push_back(16'd1);
    host_addr = SEM; host_cs_n = 1'b0; host_oe_n = 1'b0;
    idle(4); loc_req = 1'b1;
    idle(6); -> samp_ev;
    chk(loc_gnt === 1'b0, "R7 local lost", {15'd0, loc_gnt}, 16'd0);
    idle(1); host_oe_n = 1'b1; host_cs_n = 1'b1;
    idle(6);
    host_write(SEM, 16'h0000);
    idle(1);
    chk(loc_gnt === 1'b1, "R7 R8 local after release", {15'd0, loc_gnt}, 16'd1);
    loc_req = 1'b0; idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule